// File: doc/BRIEF.md
# Lowest-Set-Bit Manipulation Unit

This execution unit performs three bit tricks on the lowest set bit of a source operand. It can clear that bit, build a mask that runs from bit 0 up to and including that bit, or isolate that bit alone. All three operations share one decrement of the width-masked operand. The negated operand needed for isolation is formed as the inverse of that decrement.

The unit decodes a 3-bit operation selector and checks the legality conditions of the encoding: a feature enable, an extended-prefix-present flag and a vector-length bit. An operand-size input selects a 32-bit or 64-bit width. The unit then produces the result, a set of condition flags, a destination index, and write and flag-update strobes, or it raises an illegal-instruction indication.

Inputs are captured when `in_valid_i` is high, and every output appears one clock later qualified by `out_valid_o`. The destination index travels with the operation. It names the register taken from the prefix's extra-operand field, not from the instruction's selector field.

Top module: `lsb_unit`

## Requirements
- R1: Selector value 1 selects clear-lowest, 2 selects mask-to-lowest and 3 selects isolate-lowest. Any other selector value raises `illegal_o`.
- R2: An operation is illegal unless `feat_en_i`=1, `ext_prefix_i`=1 and `vec_len_i`=0. When `illegal_o` is high, `wr_en_o` and `flag_upd_o` are low and the result and all flags read as zero.
- R3: Clear-lowest returns op AND (op − 1), where op is the width-masked source.
- R4: Mask-to-lowest returns op XOR (op − 1).
- R5: Isolate-lowest returns op AND (−op).
- R6: With `wide_i`=0 only source bits 31:0 are used and result bits 63:32 are zero. A zero source under mask-to-lowest yields all ones at the active width, and the other two operations yield zero.
- R7: `zf_o` is 1 exactly when the result is zero. `sf_o` equals result bit 63 when `wide_i`=1 and result bit 31 otherwise.
- R8: `cf_o` is 1 for isolate-lowest when the width-masked source is nonzero. It is 1 for clear-lowest and mask-to-lowest when that source is zero.
- R9: `of_o`, `pf_o` and `af_o` are always 0.
- R10: `dst_idx_o` carries the `dst_idx_i` value that was captured with the operation. `wr_en_o` and `flag_upd_o` are high for each legal operation.
- R11: Outputs appear in the cycle after `in_valid_i` is sampled high. `out_valid_o` is low after a cycle without `in_valid_i`, and it is low during and after reset until the first capture. Back-to-back captures yield back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Capture strobe for the operation inputs |
| sel_i | input | 3 | Operation selector |
| ext_prefix_i | input | 1 | Extended prefix present |
| vec_len_i | input | 1 | Vector-length bit of the prefix; must be 0 |
| feat_en_i | input | 1 | Feature enable |
| wide_i | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| dst_idx_i | input | 4 | Destination register index from the prefix |
| src_i | input | 64 | Source operand |
| out_valid_o | output | 1 | Output qualifier |
| result_o | output | 64 | Operation result |
| dst_idx_o | output | 4 | Destination index for the write |
| wr_en_o | output | 1 | Destination write strobe |
| flag_upd_o | output | 1 | Flag update strobe |
| illegal_o | output | 1 | Illegal-instruction indication |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag (driven 0) |
| af_o | output | 1 | Adjust flag (driven 0) |

## Verification
Illegal-encoding suppression and the zero-source special case can land in the same cycle. For example, mask-to-lowest on a zero source would otherwise write all ones and set the carry. The bench provokes this by sending a zero source together with a cleared feature enable or a set vector-length bit. It judges the outcome at the ports: `illegal_o` must be high, both strobes low, and the result and carry zero. A second collision comes from issuing on consecutive cycles. A new capture lands in the same edge that presents the previous result, and each presented result is checked against its own operation.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [2:0] {
    LSB_OP_NONE = 3'd0,
    LSB_OP_CLR  = 3'd1,
    LSB_OP_MSK  = 3'd2,
    LSB_OP_ISO  = 3'd3
  } lsb_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
    logic af;
  } lsb_flags_t;
endpackage

// File: rtl/lsb_decode.sv
module lsb_decode
  import lsb_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_prefix_i,
  input  logic             vec_len_i,
  input  logic             feat_en_i,
  output lsb_op_e          op_o,
  output logic             legal_o
);
  logic known;

  always_comb begin
    op_o  = LSB_OP_NONE;
    known = 1'b0;
    case (sel_i)
      SEL_W'(1): begin op_o = LSB_OP_CLR; known = 1'b1; end
      SEL_W'(2): begin op_o = LSB_OP_MSK; known = 1'b1; end
      SEL_W'(3): begin op_o = LSB_OP_ISO; known = 1'b1; end
      default:   begin op_o = LSB_OP_NONE; known = 1'b0; end
    endcase
  end

  assign legal_o = known & feat_en_i & ext_prefix_i & ~vec_len_i;
endmodule

// File: rtl/lsb_core.sv
module lsb_core
  import lsb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  lsb_op_e          op_i,
  input  logic             wide_i,
  input  logic [XLEN-1:0]  src_i,
  output logic [XLEN-1:0]  res_o,
  output logic             src_zero_o
);
  localparam logic [XLEN-1:0] NARROW_MASK = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

  logic [XLEN-1:0] wmask, opnd, dec, raw;

  assign wmask = wide_i ? '1 : NARROW_MASK;
  assign opnd  = src_i & wmask;
  // single decrement; -op == ~(op-1)
  assign dec   = opnd - XLEN'(1);

  always_comb begin
    case (op_i)
      LSB_OP_CLR: raw = opnd & dec;
      LSB_OP_MSK: raw = opnd ^ dec;
      LSB_OP_ISO: raw = opnd & ~dec;
      default:    raw = '0;
    endcase
  end

  assign res_o      = raw & wmask;
  assign src_zero_o = (opnd == '0);
endmodule

// File: rtl/lsb_flags.sv
module lsb_flags
  import lsb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  lsb_op_e         op_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] res_i,
  input  logic            src_zero_i,
  output lsb_flags_t      flags_o
);
  always_comb begin
    flags_o    = '0;
    flags_o.cf = (op_i == LSB_OP_ISO) ? ~src_zero_i : src_zero_i;
    flags_o.zf = (res_i == '0);
    flags_o.sf = wide_i ? res_i[XLEN-1] : res_i[HALF-1];
  end
endmodule

// File: rtl/lsb_unit.sv
module lsb_unit
  import lsb_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  parameter int SEL_W = 3,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_prefix_i,
  input  logic             vec_len_i,
  input  logic             feat_en_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [XLEN-1:0]  src_i,
  output logic             out_valid_o,
  output logic [XLEN-1:0]  result_o,
  output logic [IDX_W-1:0] dst_idx_o,
  output logic             wr_en_o,
  output logic             flag_upd_o,
  output logic             illegal_o,
  output logic             cf_o,
  output logic             zf_o,
  output logic             sf_o,
  output logic             of_o,
  output logic             pf_o,
  output logic             af_o
);
  lsb_op_e         op;
  logic            legal, src_zero;
  logic [XLEN-1:0] res;
  lsb_flags_t      flags;

  lsb_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i(sel_i), .ext_prefix_i(ext_prefix_i), .vec_len_i(vec_len_i),
    .feat_en_i(feat_en_i), .op_o(op), .legal_o(legal)
  );

  lsb_core #(.XLEN(XLEN), .HALF(HALF)) u_core (
    .op_i(op), .wide_i(wide_i), .src_i(src_i), .res_o(res), .src_zero_o(src_zero)
  );

  lsb_flags #(.XLEN(XLEN), .HALF(HALF)) u_flags (
    .op_i(op), .wide_i(wide_i), .res_i(res), .src_zero_i(src_zero), .flags_o(flags)
  );

  logic             vld_q, legal_q;
  logic [XLEN-1:0]  res_q;
  lsb_flags_t       flags_q;
  logic [IDX_W-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      legal_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      dst_q   <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        legal_q <= legal;
        res_q   <= legal ? res : '0;
        flags_q <= legal ? flags : '0;
        dst_q   <= dst_idx_i;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;
  assign dst_idx_o   = dst_q;
  assign wr_en_o     = vld_q & legal_q;
  assign flag_upd_o  = vld_q & legal_q;
  assign illegal_o   = vld_q & ~legal_q;
  assign cf_o        = flags_q.cf;
  assign zf_o        = flags_q.zf;
  assign sf_o        = flags_q.sf;
  assign of_o        = flags_q.of;
  assign pf_o        = flags_q.pf;
  assign af_o        = flags_q.af;

  a_r11_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r2_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !flag_upd_o && result_o == '0));
  a_r2_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (!feat_en_i || !ext_prefix_i || vec_len_i)) |=> illegal_o);
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !wide_i) |=> (result_o[XLEN-1:HALF] == '0));
  a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (zf_o == (result_o == '0)));
  a_r10_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (dst_idx_o == $past(dst_idx_i)));
  a_r8_iso_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && legal && sel_i == SEL_W'(3) && wide_i && src_i != '0) |=> cf_o);
endmodule

// File: tb/lsb_unit_tb_top.sv
`timescale 1ns/1ps
module lsb_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic        ext_prefix_i = 1'b1;
  logic        vec_len_i = 1'b0;
  logic        feat_en_i = 1'b1;
  logic        wide_i = 1'b1;
  logic [3:0]  dst_idx_i = '0;
  logic [63:0] src_i = '0;
  logic        out_valid_o, wr_en_o, flag_upd_o, illegal_o;
  logic        cf_o, zf_o, sf_o, of_o, pf_o, af_o;
  logic [63:0] result_o;
  logic [3:0]  dst_idx_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  lsb_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .sel_i(sel_i),
    .ext_prefix_i(ext_prefix_i), .vec_len_i(vec_len_i), .feat_en_i(feat_en_i),
    .wide_i(wide_i), .dst_idx_i(dst_idx_i), .src_i(src_i),
    .out_valid_o(out_valid_o), .result_o(result_o), .dst_idx_o(dst_idx_o),
    .wr_en_o(wr_en_o), .flag_upd_o(flag_upd_o), .illegal_o(illegal_o),
    .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .pf_o(pf_o), .af_o(af_o)
  );

  localparam int NV = 14;
  localparam logic [2:0] V_SEL [NV] = '{3'd1, 3'd2, 3'd3, 3'd1, 3'd2, 3'd3, 3'd2,
                                        3'd3, 3'd1, 3'd3, 3'd2, 3'd1, 3'd2, 3'd3};
  localparam logic V_WIDE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                                   1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [63:0] V_SRC [NV] = '{
    64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00F0,
    64'h0, 64'h0, 64'h0, 64'h0,
    64'hFFFF_0000_0000_0000, 64'h1234_5678_8000_0000, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'hAAAA_AAAA_0000_0006, 64'h0000_0000_8000_0000,
    64'h0000_0001_0000_0003};
  localparam logic [63:0] V_RES [NV] = '{
    64'hE0, 64'h1F, 64'h10,
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0000_FFFF_FFFF,
    64'h0, 64'h0, 64'h8000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h4, 64'h0000_0000_FFFF_FFFF, 64'h1};
  localparam logic V_CF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, return at next negedge for sampling
  task automatic issue(input logic [2:0] s, input logic w, input logic [63:0] src,
                       input logic [3:0] idx);
    sel_i = s; wide_i = w; src_i = src; dst_idx_i = idx; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic chk_legal(input string req, input logic [63:0] er, input logic ecf,
                           input logic w, input logic [3:0] idx);
    logic esf;
    esf = w ? er[63] : er[31];
    chk("R11", "out_valid", {63'b0, out_valid_o}, 64'd1);
    chk(req, "result", result_o, er);
    chk("R8", "cf", {63'b0, cf_o}, {63'b0, ecf});
    chk("R7", "zf", {63'b0, zf_o}, {63'b0, er == 64'd0});
    chk("R7", "sf", {63'b0, sf_o}, {63'b0, esf});
    chk("R9", "of/pf/af", {61'b0, of_o, pf_o, af_o}, 64'd0);
    chk("R10", "wr/upd/ill", {61'b0, wr_en_o, flag_upd_o, illegal_o}, 64'd6);
    chk("R10", "dst_idx", {60'b0, dst_idx_o}, {60'b0, idx});
  endtask

  task automatic chk_illegal(input string req);
    chk(req, "wr/upd/ill", {61'b0, wr_en_o, flag_upd_o, illegal_o}, 64'd1);
    chk("R2", "result", result_o, 64'd0);
    chk("R2", "flags", {58'b0, cf_o, zf_o, sf_o, of_o, pf_o, af_o}, 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11", "out_valid in reset", {63'b0, out_valid_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "out_valid after reset", {63'b0, out_valid_o}, 64'd0);

    // table: R3 clear, R4 mask, R5 isolate, R6 narrow width
    for (int i = 0; i < NV; i++) begin
      issue(V_SEL[i], V_WIDE[i], V_SRC[i], 4'(i));
      chk_legal(V_SEL[i] == 3'd1 ? "R3" : V_SEL[i] == 3'd2 ? "R4" : "R5",
                V_RES[i], V_CF[i], V_WIDE[i], 4'(i));
      if (!V_WIDE[i]) chk("R6", "upper zero", {32'b0, result_o[63:32]}, 64'd0);
    end

    // R11 idle cycle
    @(negedge clk_i);
    chk("R11", "idle out_valid", {63'b0, out_valid_o}, 64'd0);

    // R1 unknown selectors
    issue(3'd0, 1'b1, 64'hF0, 4'd1); chk_illegal("R1");
    issue(3'd4, 1'b1, 64'hF0, 4'd1); chk_illegal("R1");
    issue(3'd7, 1'b1, 64'hF0, 4'd1); chk_illegal("R1");

    // R2 legality gates, coinciding with zero-source mask
    feat_en_i = 1'b0;
    issue(3'd2, 1'b1, 64'h0, 4'd2); chk_illegal("R2");
    feat_en_i = 1'b1; ext_prefix_i = 1'b0;
    issue(3'd2, 1'b1, 64'h0, 4'd2); chk_illegal("R2");
    ext_prefix_i = 1'b1; vec_len_i = 1'b1;
    issue(3'd3, 1'b0, 64'h5, 4'd2); chk_illegal("R2");
    vec_len_i = 1'b0;

    // R11 back-to-back captures
    sel_i = 3'd3; wide_i = 1'b1; src_i = 64'h0000_0000_0000_0C00; dst_idx_i = 4'd9;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    chk_legal("R11", 64'h400, 1'b1, 1'b1, 4'd9);
    sel_i = 3'd1; src_i = 64'h0000_0000_0000_0C00; dst_idx_i = 4'd10;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk_legal("R11", 64'h800, 1'b0, 1'b1, 4'd10);
    @(negedge clk_i);
    chk("R11", "drop after burst", {63'b0, out_valid_o}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule